// File: doc/BRIEF.md
# Keyboard Character Receiver Port

This block sits on a 32-bit processor load/store bus in the system address region above 0x7FFFFFFF. It takes one character at a time from a keyboard-side source, which presents a byte together with a one-cycle valid strobe. It holds that character for software in a single-entry latch. Software finds the character either by polling a status word or by enabling an interrupt that stays asserted while a character waits.

Two bus words are decoded. The status/control word sits at the base address 0xFFFF0000. The character word sits at base plus 4 (0xFFFF0004). A load of the character word hands over the byte and marks it consumed. A store to the status/control word changes only the interrupt-enable bit. Read data is registered and appears on the cycle after the load is presented. Every other address in the window reads as zero and ignores stores.

Top module: `kbrx_port`

## Requirements
- R1: After synchronous reset, the character-waiting flag, the interrupt-enable flag and `irq` are 0. A load of either word returns 0.
- R2: A cycle with `key_valid` high latches `key_data` and sets the character-waiting flag. The flag reads back as bit 0 of the status/control word at 0xFFFF0000.
- R3: A load at 0xFFFF0004 returns the latched character in bits 7:0 with bits 31:8 zero. The data appears on `bus_rdata` one cycle after the load is presented, and the same load clears the character-waiting flag.
- R4: A load at 0xFFFF0000 returns the character-waiting flag in bit 0 and the interrupt-enable flag in bit 1, with bits 31:2 zero.
- R5: A store to 0xFFFF0000 copies write-data bit 1 into the interrupt-enable flag. Write-data bit 0 is ignored, so the store never sets or clears the character-waiting flag.
- R6: `irq` is high exactly when the character-waiting flag and the interrupt-enable flag are both 1. It stays high as a level until the character is taken by a load at 0xFFFF0004 or interrupts are disabled.
- R7: A character that arrives while the flag is already set replaces the latched character, and the flag stays set.
- R8: When a load at 0xFFFF0004 and `key_valid` fall in the same cycle, the load returns the previous character, the new character is latched, and the flag stays set.
- R9: A load of any address other than the two words returns 0 and leaves the flag unchanged. A store to any address other than 0xFFFF0000, including 0xFFFF0004, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access presented this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Registered load data, valid the cycle after a load |
| key_valid | input | 1 | One-cycle strobe: a character is offered |
| key_data | input | 8 | Offered character |
| irq | output | 1 | Level interrupt request |

## Verification
The collision that matters is a software load of the character word in the same cycle that a new character arrives. One side wants to clear the waiting flag and the other wants to set it, and the latch is both read and rewritten. The bench drives both on one clock edge. It expects the load to return the older character, the status word to still show a waiting character with `irq` still high, and a second load to return the newer character. A status store carrying bit 0 in the same cycle a character waits is also judged, by reading the flag back.

// File: rtl/kbrx_pkg.sv
package kbrx_pkg;
  // Which register an access decodes to
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2
  } kbrx_sel_e;

  localparam logic [31:0] KBRX_DEFAULT_BASE = 32'hFFFF_0000;
  localparam int unsigned KBRX_DATA_OFFSET  = 4;
  // bit positions inside the status/control word
  localparam int unsigned KBRX_BIT_READY = 0;
  localparam int unsigned KBRX_BIT_IE    = 1;
endpackage

// File: rtl/kbrx_decode.sv
module kbrx_decode
  import kbrx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = KBRX_DEFAULT_BASE
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output kbrx_sel_e         hit,
  output logic              rd,
  output logic              wr
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE + ADDR_W'(KBRX_DATA_OFFSET);

  always_comb begin
    hit = SEL_NONE;
    if (bus_addr == BASE)           hit = SEL_CTRL;
    else if (bus_addr == DATA_ADDR) hit = SEL_DATA;
    rd = bus_sel && !bus_we;
    wr = bus_sel && bus_we;
  end
endmodule

// File: rtl/kbrx_state.sv
module kbrx_state
  import kbrx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  kbrx_sel_e         hit,
  input  logic              rd,
  input  logic              wr,
  input  logic              ie_wbit,
  input  logic              key_valid,
  input  logic [DATA_W-1:0] key_data,
  output logic              ready_q,
  output logic              ie_q,
  output logic [DATA_W-1:0] char_q,
  output logic              irq_q
);
  logic              ready_d;
  logic              ie_d;
  logic [DATA_W-1:0] char_d;

  always_comb begin
    ready_d = ready_q;
    // taking the character clears the flag; an arrival in the same cycle wins
    if (rd && hit == SEL_DATA) ready_d = 1'b0;
    if (key_valid)             ready_d = 1'b1;

    ie_d = ie_q;
    if (wr && hit == SEL_CTRL) ie_d = ie_wbit;

    char_d = key_valid ? key_data : char_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      ie_q    <= 1'b0;
      char_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      ready_q <= ready_d;
      ie_q    <= ie_d;
      char_q  <= char_d;
      // registered so that irq lines up with the flags it is built from
      irq_q   <= ready_d & ie_d;
    end
  end
endmodule

// File: rtl/kbrx_readmux.sv
module kbrx_readmux
  import kbrx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  kbrx_sel_e         hit,
  input  logic              rd,
  input  logic              ready_q,
  input  logic              ie_q,
  input  logic [DATA_W-1:0] char_q,
  output logic [BUS_W-1:0]  rdata_q
);
  logic [BUS_W-1:0] char_word;
  logic [BUS_W-1:0] ctrl_word;

  generate
    if (DATA_W < BUS_W) begin : g_pad
      assign char_word = {{(BUS_W-DATA_W){1'b0}}, char_q};
    end else begin : g_trunc
      assign char_word = char_q[BUS_W-1:0];
    end
  endgenerate

  always_comb begin
    ctrl_word = '0;
    ctrl_word[KBRX_BIT_READY] = ready_q;
    ctrl_word[KBRX_BIT_IE]    = ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd) begin
      unique case (hit)
        SEL_CTRL: rdata_q <= ctrl_word;
        SEL_DATA: rdata_q <= char_word;
        default:  rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end
endmodule

// File: rtl/kbrx_port.sv
module kbrx_port
  import kbrx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = KBRX_DEFAULT_BASE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              key_valid,
  input  logic [DATA_W-1:0] key_data,
  output logic              irq
);
  kbrx_sel_e         hit;
  logic              rd;
  logic              wr;
  logic              ready_q;
  logic              ie_q;
  logic [DATA_W-1:0] char_q;

  // only the enable bit of a store is used
  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[BUS_W-1:KBRX_BIT_IE+1], bus_wdata[KBRX_BIT_READY]};

  kbrx_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .hit      (hit),
    .rd       (rd),
    .wr       (wr)
  );

  kbrx_state #(.DATA_W(DATA_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .rd        (rd),
    .wr        (wr),
    .ie_wbit   (bus_wdata[KBRX_BIT_IE]),
    .key_valid (key_valid),
    .key_data  (key_data),
    .ready_q   (ready_q),
    .ie_q      (ie_q),
    .char_q    (char_q),
    .irq_q     (irq)
  );

  kbrx_readmux #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_readmux (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .rd      (rd),
    .ready_q (ready_q),
    .ie_q    (ie_q),
    .char_q  (char_q),
    .rdata_q (bus_rdata)
  );
endmodule

// File: rtl/kbrx_port_chk.sv
module kbrx_port_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              key_valid,
  input logic [DATA_W-1:0] key_data,
  input logic              irq,
  input logic              ready_q,
  input logic              ie_q,
  input logic [DATA_W-1:0] char_q
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE + ADDR_W'(4);

  logic ld_data, ld_other, st_ctrl;
  assign ld_data  = bus_sel && !bus_we && bus_addr == DATA_ADDR;
  assign ld_other = bus_sel && !bus_we && bus_addr != DATA_ADDR && bus_addr != BASE;
  assign st_ctrl  = bus_sel && bus_we && bus_addr == BASE;

  // R2
  key_sets_ready_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> ready_q);

  // R7
  key_latches_char_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> char_q == $past(key_data));

  // R3
  load_clears_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_data && !key_valid) |=> !ready_q);

  // R3
  load_returns_char_chk: assert property (@(posedge clk) disable iff (rst)
    ld_data |=> bus_rdata == BUS_W'($past(char_q)));

  // R5
  store_sets_ie_chk: assert property (@(posedge clk) disable iff (rst)
    st_ctrl |=> ie_q == $past(bus_wdata[1]));

  // R5
  store_keeps_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (st_ctrl && !key_valid) |=> ready_q == $past(ready_q));

  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ready_q && ie_q));

  // R9
  other_load_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ld_other |=> bus_rdata == '0);
endmodule

bind kbrx_port kbrx_port_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W), .BASE(BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .key_valid (key_valid),
  .key_data  (key_data),
  .irq       (irq),
  .ready_q   (ready_q),
  .ie_q      (ie_q),
  .char_q    (char_q)
);

// File: tb/kbrx_port_bench.sv
`timescale 1ns/1ps
module kbrx_port_bench;
  localparam logic [31:0] CTRL = 32'hFFFF_0000;
  localparam logic [31:0] DATA = 32'hFFFF_0004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        key_valid = 1'b0;
  logic [7:0]  key_data = '0;
  logic        irq;

  int compared = 0;
  int mismatched = 0;

  // bench-side model of the register state
  logic       m_ready = 1'b0;
  logic       m_ie = 1'b0;
  logic [7:0] m_char = '0;

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_pend = 1'b0;

  always #2 clk = ~clk;

  kbrx_port u_kbrx_port (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_valid(key_valid), .key_data(key_data), .irq(irq)
  );

  // monitor: a load presented at an edge has its data sampled at the next negedge
  always @(posedge clk) rd_pend <= bus_sel && !bus_we && !rst;

  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (bus_rdata !== e) begin
        mismatched++;
        $display("FAIL %s: bus_rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic check_irq(input string tag);
    compared++;
    if (irq !== (m_ready & m_ie)) begin
      mismatched++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, m_ready & m_ie);
    end
  endtask

  // one bus access, optionally with a key arrival in the same cycle
  task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                        input logic kv, input logic [7:0] kd, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
    key_valid = kv; key_data = kd;
    if (!we) begin
      if (addr == CTRL)      exp_q.push_back({30'd0, m_ie, m_ready});
      else if (addr == DATA) exp_q.push_back({24'd0, m_char});
      else                   exp_q.push_back(32'd0);
      tag_q.push_back(tag);
      if (addr == DATA) m_ready = 1'b0;
    end else if (addr == CTRL) begin
      m_ie = wd[1];
    end
    if (kv) begin m_ready = 1'b1; m_char = kd; end
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; key_valid = 1'b0;
  endtask

  task automatic load(input logic [31:0] addr, input string tag);
    access(1'b0, addr, 32'd0, 1'b0, 8'd0, tag);
  endtask

  task automatic store(input logic [31:0] addr, input logic [31:0] wd);
    access(1'b1, addr, wd, 1'b0, 8'd0, "store");
  endtask

  task automatic key(input logic [7:0] kd);
    @(negedge clk);
    key_valid = 1'b1; key_data = kd;
    m_ready = 1'b1; m_char = kd;
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic finish_run;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_irq("R1 irq after reset");
    load(CTRL, "R1 status after reset");
    load(DATA, "R1 char after reset");

    // R2 arrival, R4 status format, R6 no irq while disabled
    key(8'h41);
    load(CTRL, "R2 ready flag set");
    check_irq("R6 irq low while disabled");
    load(DATA, "R3 char read");
    load(CTRL, "R3 flag cleared by load");

    // R5 enable bit; bit 0 of the store ignored
    store(CTRL, 32'h2);
    load(CTRL, "R4 status shows enable");
    store(CTRL, 32'h1);
    load(CTRL, "R5 bit0 store does not set ready");
    store(CTRL, 32'hFFFF_FFFF);
    load(CTRL, "R5 all-ones store sets only enable");

    // R6 level interrupt
    key(8'h71);
    check_irq("R6 irq raised");
    repeat (4) @(negedge clk);
    check_irq("R6 irq held as level");
    store(CTRL, 32'h2);
    load(CTRL, "R5 bit0 clear store keeps ready");
    load(DATA, "R3 char with irq");
    check_irq("R6 irq dropped after load");

    // R7 overwrite
    key(8'h10);
    key(8'h20);
    load(DATA, "R7 newest char kept");
    load(CTRL, "R7 flag cleared after load");

    // several patterns back to back
    for (int i = 0; i < 6; i++) begin
      key(8'(8'hA5 ^ (i * 37)));
      check_irq("R6 irq per char");
      load(DATA, "R3 pattern char");
    end

    // R8 load and arrival in the same cycle
    key(8'h30);
    access(1'b0, DATA, 32'd0, 1'b1, 8'h55, "R8 load returns older char");
    load(CTRL, "R8 flag still set");
    check_irq("R8 irq still high");
    load(DATA, "R8 newer char retained");

    // R9 other addresses and stores to the data word
    key(8'h66);
    load(32'hFFFF_0008, "R9 other window address reads zero");
    load(32'h0000_0000, "R9 low address reads zero");
    load(32'hFFFF_0001, "R9 misaligned address reads zero");
    store(DATA, 32'h99);
    store(32'hFFFF_0008, 32'h0);
    store(32'hFFFF_0002, 32'h0);
    load(CTRL, "R9 flags untouched by other accesses");
    load(DATA, "R9 char untouched by stores");

    // disable and check irq stays low with a waiting char
    store(CTRL, 32'h0);
    key(8'h7E);
    check_irq("R6 irq low after disable");
    load(CTRL, "R4 status ready without enable");

    finish_run();
  end
endmodule